// File: doc/BRIEF.md
# Serial Divider Configuration Loader

This block takes the three-wire serial programming stream of a frequency synthesizer and turns it into parallel divider settings. The three wires are a data line, a shift clock and a latch strobe. All three are sampled by the system clock. A rising edge on the shift clock moves one data bit into a 19-bit shift register. The word is sent most significant bit first, so the bit sent last ends up in the least significant position, which holds the control bit.

A rising edge on the latch strobe copies the shift register into one of two holding banks, and the control bit picks the bank. A high control bit loads the reference bank, which holds a 14-bit reference ratio and four mode bits. A low control bit loads the divider bank, which holds a 7-bit swallow value and an 11-bit main value. Each bank has a flag that is set once the bank has been loaded. An error flag reports a loaded reference or main ratio below the legal minimum of 3. The counters and analog circuits that use these settings lie outside this block.

Top module: `ser_div_loader`

## Requirements
- R1: After reset, every output is 0: all fields, both valid flags and the error flag.
- R2: Each rising edge of `ser_clk` shifts `ser_data` into the least significant end of the 19-bit shift register. Only the last 19 bits shifted before a latch count.
- R3: A rising edge of `ser_le` with control bit (word bit 0) equal to 1 loads the reference bank. `ref_ratio` takes word bits 14..1, `pre_sel` bit 15, `phase_pol` bit 16, `ld_sel` bit 17 and `cp_sel` bit 18. The outputs show the new values two system clocks after `ser_le` is seen high.
- R4: A rising edge of `ser_le` with control bit 0 loads the divider bank. `swallow` takes word bits 7..1 and `main_div` takes word bits 18..8.
- R5: A load into one bank leaves every field of the other bank unchanged.
- R6: The holding banks change only on a rising edge of `ser_le`. Shifting with `ser_le` low, or with `ser_le` held high, leaves every field unchanged.
- R7: `ref_valid` and `div_valid` are 0 until their bank is first loaded, then stay at 1 until reset.
- R8: `ratio_err` is 1 exactly while a loaded bank holds a ratio below 3: `ref_ratio` when `ref_valid` is 1, or `main_div` when `div_valid` is 1. It returns to 0 when a legal value is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial shift clock, rising edge shifts |
| ser_le | input | 1 | Latch strobe, rising edge loads a bank |
| ref_ratio | output | 14 | Reference divide ratio |
| pre_sel | output | 1 | Prescaler modulus select |
| phase_pol | output | 1 | Phase comparator polarity |
| ld_sel | output | 1 | Lock-detect / reference output select |
| cp_sel | output | 1 | Charge-pump current select |
| swallow | output | 7 | Swallow count |
| main_div | output | 11 | Main divide count |
| ref_valid | output | 1 | Reference bank has been loaded |
| div_valid | output | 1 | Divider bank has been loaded |
| ratio_err | output | 1 | A loaded ratio is below 3 |

## Verification
Most internal faults reach the ports only at the next latch. A dropped or doubled shift, a wrong bit order or a misrouted control bit stays hidden in the shift register and shows up two system clocks after the strobe as a wrong field in one bank. A bank that updates without a strobe edge shows at once as a field that changes while a word is being shifted. For this reason every latch is followed by a check of both banks in full, and a word is also shifted with no strobe and with the strobe held high.

// File: rtl/ser_div_loader.sv
module ser_div_loader #(
  parameter int SR_W      = 19,
  parameter int R_W       = 14,
  parameter int A_W       = 7,
  parameter int N_W       = 11,
  parameter int MIN_RATIO = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_data,
  input  logic           ser_clk,
  input  logic           ser_le,
  output logic [R_W-1:0] ref_ratio,
  output logic           pre_sel,
  output logic           phase_pol,
  output logic           ld_sel,
  output logic           cp_sel,
  output logic [A_W-1:0] swallow,
  output logic [N_W-1:0] main_div,
  output logic           ref_valid,
  output logic           div_valid,
  output logic           ratio_err
);
  localparam int MODE_LO = R_W + 1;
  localparam int N_LO    = A_W + 1;

  logic            data_q, sclk_q, sclk_qq, le_q, le_qq;
  logic [SR_W-1:0] sreg;
  logic            shift_en, latch_en;

  assign shift_en = sclk_q & ~sclk_qq;
  assign latch_en = le_q & ~le_qq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= 1'b0;
      sclk_q  <= 1'b0;
      sclk_qq <= 1'b0;
      le_q    <= 1'b0;
      le_qq   <= 1'b0;
    end else begin
      data_q  <= ser_data;
      sclk_q  <= ser_clk;
      sclk_qq <= sclk_q;
      le_q    <= ser_le;
      le_qq   <= le_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sreg <= '0;
    else if (shift_en) sreg <= {sreg[SR_W-2:0], data_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_ratio <= '0;
      pre_sel   <= 1'b0;
      phase_pol <= 1'b0;
      ld_sel    <= 1'b0;
      cp_sel    <= 1'b0;
      ref_valid <= 1'b0;
      swallow   <= '0;
      main_div  <= '0;
      div_valid <= 1'b0;
    end else if (latch_en) begin
      if (sreg[0]) begin
        ref_ratio <= sreg[R_W:1];
        pre_sel   <= sreg[MODE_LO];
        phase_pol <= sreg[MODE_LO+1];
        ld_sel    <= sreg[MODE_LO+2];
        cp_sel    <= sreg[MODE_LO+3];
        ref_valid <= 1'b1;
      end else begin
        swallow   <= sreg[A_W:1];
        main_div  <= sreg[N_LO+N_W-1:N_LO];
        div_valid <= 1'b1;
      end
    end
  end

  assign ratio_err = (ref_valid && (ref_ratio < R_W'(MIN_RATIO))) ||
                     (div_valid && (main_div  < N_W'(MIN_RATIO)));
endmodule

// File: rtl/ser_div_loader_chk.sv
module ser_div_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ser_le,
  input logic [18:0] sreg,
  input logic [13:0] ref_ratio,
  input logic        pre_sel,
  input logic        phase_pol,
  input logic        ld_sel,
  input logic        cp_sel,
  input logic [6:0]  swallow,
  input logic [10:0] main_div,
  input logic        ref_valid,
  input logic        div_valid,
  input logic        ratio_err
);
  logic le_d1, le_d2, le_rise;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      le_d1 <= 1'b0;
      le_d2 <= 1'b0;
    end else begin
      le_d1 <= ser_le;
      le_d2 <= le_d1;
    end
  end
  assign le_rise = le_d1 & ~le_d2;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> $stable({ref_ratio, pre_sel, phase_pol, ld_sel, cp_sel, swallow, main_div}));

  p_ref_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && sreg[0]) |=> (ref_ratio == $past(sreg[14:1])) && (cp_sel == $past(sreg[18])));

  p_div_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && !sreg[0]) |=> (main_div == $past(sreg[18:8])) && (swallow == $past(sreg[7:1])));

  p_bank_sep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && !sreg[0]) |=> $stable({ref_ratio, pre_sel, phase_pol, ld_sel, cp_sel}));

  p_valid_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid |=> ref_valid) and (div_valid |=> div_valid));

  p_err_needs_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_err |-> (ref_valid || div_valid));
endmodule

bind ser_div_loader ser_div_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ser_le(ser_le), .sreg(sreg),
  .ref_ratio(ref_ratio), .pre_sel(pre_sel), .phase_pol(phase_pol),
  .ld_sel(ld_sel), .cp_sel(cp_sel), .swallow(swallow), .main_div(main_div),
  .ref_valid(ref_valid), .div_valid(div_valid), .ratio_err(ratio_err)
);

// File: tb/test_ser_div_loader.sv
module test_ser_div_loader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_le = 1'b0;
  logic [13:0] ref_ratio;
  logic pre_sel, phase_pol, ld_sel, cp_sel;
  logic [6:0] swallow;
  logic [10:0] main_div;
  logic ref_valid, div_valid, ratio_err;

  int n_chk = 0, n_fail = 0;

  logic [17:0] m_ref = '0, m_div = '0;
  logic m_rv = 1'b0, m_dv = 1'b0;

  always #10 clk = ~clk;

  ser_div_loader i_ser_div_loader (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk), .ser_le(ser_le),
    .ref_ratio(ref_ratio), .pre_sel(pre_sel), .phase_pol(phase_pol), .ld_sel(ld_sel),
    .cp_sel(cp_sel), .swallow(swallow), .main_div(main_div),
    .ref_valid(ref_valid), .div_valid(div_valid), .ratio_err(ratio_err)
  );

  localparam logic [18:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b1, 1'b0, 14'd1000,  1'b1},
    {11'd1500, 7'd37,  1'b0},
    {1'b0, 1'b1, 1'b0, 1'b1, 14'd16383, 1'b1},
    {11'd2047, 7'd127, 1'b0},
    {1'b1, 1'b1, 1'b1, 1'b1, 14'd3,     1'b1},
    {11'd3,    7'd0,   1'b0},
    {11'd1234, 7'd85,  1'b0},
    {1'b0, 1'b0, 1'b0, 1'b0, 14'd12345, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] w, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_data = w[i];
      tick(2);
      ser_clk = 1'b1;
      tick(3);
      ser_clk = 1'b0;
      tick(2);
    end
  endtask

  task automatic latch(input logic [18:0] w);
    ser_le = 1'b1;
    tick(4);
    ser_le = 1'b0;
    tick(3);
    if (w[0]) begin m_ref = w[18:1]; m_rv = 1'b1; end
    else      begin m_div = w[18:1]; m_dv = 1'b1; end
  endtask

  task automatic load(input logic [18:0] w);
    send_bits({13'd0, w}, 19);
    latch(w);
  endtask

  task automatic check_all(input string req);
    logic exp_err;
    exp_err = (m_rv && m_ref[13:0] < 14'd3) || (m_dv && m_div[17:7] < 11'd3);
    chk({req, " ref_ratio"}, 32'(ref_ratio), 32'(m_ref[13:0]));
    chk({req, " mode"}, 32'({cp_sel, ld_sel, phase_pol, pre_sel}), 32'(m_ref[17:14]));
    chk({req, " swallow"}, 32'(swallow), 32'(m_div[6:0]));
    chk({req, " main_div"}, 32'(main_div), 32'(m_div[17:7]));
    chk({req, " valid R7"}, 32'({ref_valid, div_valid}), 32'({m_rv, m_dv}));
    chk({req, " err R8"}, 32'(ratio_err), 32'(exp_err));
  endtask

  initial begin
    tick(200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    tick(3);
    check_all("R1 reset");
    rst_n = 1'b1;
    tick(2);

    for (int k = 0; k < 8; k++) begin
      load(VEC[k]);
      check_all(VEC[k][0] ? "R3 R5 ref load" : "R4 R5 div load");
    end

    load({1'b0, 1'b0, 1'b0, 1'b0, 14'd2, 1'b1});
    check_all("R8 ref ratio 2");
    chk("R8 err set", 32'(ratio_err), 32'd1);
    load({1'b1, 1'b0, 1'b0, 1'b1, 14'd500, 1'b1});
    check_all("R8 ref corrected");
    load({11'd1, 7'd9, 1'b0});
    check_all("R8 main ratio 1");
    load({11'd100, 7'd9, 1'b0});
    check_all("R8 main corrected");

    send_bits({13'd0, 11'd77, 7'd5, 1'b0}, 19);
    check_all("R6 shift no strobe");
    ser_le = 1'b1;
    tick(4);
    load({13'd0, 11'd99, 7'd1, 1'b0});
    ser_le = 1'b0;
    tick(3);
    m_div = {11'd77, 7'd5};
    check_all("R6 strobe held high");

    send_bits(32'h3F, 6);
    load({1'b0, 1'b1, 1'b1, 1'b0, 14'd4321, 1'b1});
    check_all("R2 extra leading bits");

    rst_n = 1'b0;
    tick(2);
    m_ref = '0; m_div = '0; m_rv = 1'b0; m_dv = 1'b0;
    check_all("R1 reset again");
    rst_n = 1'b1;
    tick(2);
    load({11'd8, 7'd2, 1'b0});
    check_all("R7 div only after reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule